// File: doc/BRIEF.md
# Interrupt Destination Match Unit

Each local interrupt controller in a multiprocessor fabric holds one copy of this unit. It looks at every interrupt message that passes the controller and decides whether the message is meant for this controller. A message carries a destination field and a flag that selects physical or logical addressing. The controller itself runs in one of two widths: a legacy mode with an 8-bit addressing space and an extended mode with a 32-bit one.

A single compare path covers four ways of addressing a controller. The first is an exact match on the controller's own physical ID. The second is an all-ones broadcast that every controller accepts. The third is a flat logical bitmap with one bit per CPU, where a single message can reach several controllers at once. The fourth is a clustered logical form: a cluster number in the upper half and a bitmap of CPUs in that cluster in the lower half.

The result comes out as a registered pulse, one cycle after the message.

Top module: `irq_dest_match`

## Requirements
- R1: `acceptOut` is low out of reset. It goes high in exactly the cycle after a valid message that matches, and it is low in every cycle that follows a cycle with `msgValid` low.
- R2: In legacy physical mode (`extMode`=0, `destLogical`=0), a message is accepted when `destField[7:0]` equals `selfId[7:0]`.
- R3: In legacy physical mode, `destField[7:0]`=0xFF is a broadcast and is accepted whatever the value of `selfId`.
- R4: In legacy logical mode (`extMode`=0, `destLogical`=1), a message is accepted when `destField[7:0] & logicalReg[7:0]` is nonzero. The destination may have several bits set.
- R5: In extended physical mode (`extMode`=1, `destLogical`=0), a message is accepted only when all 32 bits of `destField` equal `selfId`.
- R6: In extended physical mode, `destField`=0xFFFFFFFF is a broadcast and is always accepted.
- R7: In extended logical mode (`extMode`=1, `destLogical`=1), bits [31:16] hold the cluster number and bits [15:0] hold the CPU bitmap. A message is accepted only when the cluster numbers of `destField` and `logicalReg` are equal and their bitmaps share at least one set bit.
- R8: In legacy mode, bits [31:8] of `destField`, `selfId` and `logicalReg` have no effect on the result.
- R9: A logical message whose destination is all zero is never accepted, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msgValid | input | 1 | A message is present this cycle |
| destLogical | input | 1 | 1 = logical destination, 0 = physical |
| extMode | input | 1 | 1 = extended 32-bit mode, 0 = legacy 8-bit mode |
| destField | input | 32 | Destination field of the message |
| selfId | input | 32 | This controller's physical ID |
| logicalReg | input | 32 | This controller's logical destination value |
| acceptOut | output | 1 | Registered accept pulse |

## Verification
A broadcast can also be an exact ID match. This happens when the controller's own ID is all ones: 0xFF in legacy mode, or 0xFFFFFFFF in extended mode. The bench sets up both cases and expects a single accept pulse.

The registered result of one message also shares a cycle with the decode of the next message. The bench sends back-to-back messages that switch mode and expected outcome. It checks that each pulse follows its own message, and that the cycle after the burst is low.

// File: rtl/idm_pkg.sv
package idm_pkg;
  // One-hot addressing scheme strobes from control to datapath
  typedef struct packed {
    logic legPhys;
    logic legLog;
    logic extPhys;
    logic extLog;
  } idm_sel_t;
endpackage

// File: rtl/idm_ctrl.sv
module idm_ctrl
  import idm_pkg::*;
(
  input  logic     msgValid,
  input  logic     destLogical,
  input  logic     extMode,
  output idm_sel_t sel
);
  always_comb begin
    sel         = '0;
    sel.legPhys = msgValid & ~extMode & ~destLogical;
    sel.legLog  = msgValid & ~extMode &  destLogical;
    sel.extPhys = msgValid &  extMode & ~destLogical;
    sel.extLog  = msgValid &  extMode &  destLogical;
  end
endmodule

// File: rtl/idm_datapath.sv
module idm_datapath
  import idm_pkg::*;
#(
  parameter int LEG_W = 8,
  parameter int EXT_W = 32,
  parameter int CLU_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  idm_sel_t         sel,
  input  logic [EXT_W-1:0] destField,
  input  logic [EXT_W-1:0] selfId,
  input  logic [EXT_W-1:0] logicalReg,
  output logic             acceptOut
);
  localparam int MAP_W = EXT_W - CLU_W;

  logic [LEG_W-1:0] legDest, legId, legLdr;
  logic [MAP_W-1:0] mapDest, mapLdr;
  logic [CLU_W-1:0] cluDest, cluLdr;
  logic legPhysHit, legLogHit, extPhysHit, extLogHit, hitNext;

  assign legDest = destField[LEG_W-1:0];
  assign legId   = selfId[LEG_W-1:0];
  assign legLdr  = logicalReg[LEG_W-1:0];
  assign mapDest = destField[MAP_W-1:0];
  assign mapLdr  = logicalReg[MAP_W-1:0];
  assign cluDest = destField[EXT_W-1:MAP_W];
  assign cluLdr  = logicalReg[EXT_W-1:MAP_W];

  always_comb begin
    legPhysHit = (legDest == legId) || (&legDest);
    legLogHit  = |(legDest & legLdr);
    extPhysHit = (destField == selfId) || (&destField);
    extLogHit  = (cluDest == cluLdr) && (|(mapDest & mapLdr));
    hitNext    = (sel.legPhys & legPhysHit) | (sel.legLog & legLogHit) |
                 (sel.extPhys & extPhysHit) | (sel.extLog & extLogHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptOut <= 1'b0;
    else       acceptOut <= hitNext;
  end
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import idm_pkg::*;
#(
  parameter int LEG_W = 8,
  parameter int EXT_W = 32,
  parameter int CLU_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic             destLogical,
  input  logic             extMode,
  input  logic [EXT_W-1:0] destField,
  input  logic [EXT_W-1:0] selfId,
  input  logic [EXT_W-1:0] logicalReg,
  output logic             acceptOut
);
  idm_sel_t sel;

  idm_ctrl u_ctrl (
    .msgValid(msgValid), .destLogical(destLogical), .extMode(extMode), .sel(sel)
  );

  idm_datapath #(.LEG_W(LEG_W), .EXT_W(EXT_W), .CLU_W(CLU_W)) u_dp (
    .clk(clk), .rstN(rstN), .sel(sel), .destField(destField),
    .selfId(selfId), .logicalReg(logicalReg), .acceptOut(acceptOut)
  );
endmodule

// File: rtl/idm_checker.sv
module idm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        msgValid,
  input logic        destLogical,
  input logic        extMode,
  input logic [31:0] destField,
  input logic [7:0]  selfIdLo,
  input logic [31:0] logicalReg,
  input logic        acceptOut
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |=> !acceptOut); // R1
  AST_LEG_PHYS_EQ: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !extMode && !destLogical && destField[7:0] == selfIdLo) |=> acceptOut); // R2
  AST_LEG_BCAST: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !extMode && !destLogical && destField[7:0] == 8'hFF) |=> acceptOut); // R3
  AST_LEG_LOG_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !extMode && destLogical && (destField[7:0] & logicalReg[7:0]) != 8'h0) |=> acceptOut); // R4
  AST_EXT_BCAST: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && extMode && !destLogical && destField == 32'hFFFF_FFFF) |=> acceptOut); // R6
  AST_EXT_CLUSTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && extMode && destLogical && destField[31:16] != logicalReg[31:16]) |=> !acceptOut); // R7
  AST_ZERO_LOGICAL: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && destLogical && destField == 32'h0) |=> !acceptOut); // R9
endmodule

bind irq_dest_match idm_checker u_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .destLogical(destLogical),
  .extMode(extMode), .destField(destField), .selfIdLo(selfId[7:0]),
  .logicalReg(logicalReg), .acceptOut(acceptOut)
);

// File: tb/irq_dest_match_bench.sv
module irq_dest_match_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0;
  logic        destLogical = 1'b0;
  logic        extMode = 1'b0;
  logic [31:0] destField = '0;
  logic [31:0] selfId = '0;
  logic [31:0] logicalReg = '0;
  logic        acceptOut;
  int          nChecks = 0;
  int          nFails = 0;

  always #2.5 clk = ~clk;

  irq_dest_match u_irq_dest_match (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .destLogical(destLogical),
    .extMode(extMode), .destField(destField), .selfId(selfId),
    .logicalReg(logicalReg), .acceptOut(acceptOut)
  );

  task automatic check(input logic exp, input string req);
    nChecks++;
    if (acceptOut !== exp) begin
      nFails++;
      $display("FAIL %s: acceptOut=%0b expected %0b", req, acceptOut, exp);
    end
  endtask

  task automatic setMsg(input logic ext, input logic lg, input logic [31:0] d);
    msgValid = 1'b1; extMode = ext; destLogical = lg; destField = d;
  endtask

  // One message, then idle; result sampled at the negedge after capture.
  task automatic sendOne(input logic ext, input logic lg, input logic [31:0] d,
                         input logic exp, input string req);
    @(negedge clk); setMsg(ext, lg, d);
    @(negedge clk); msgValid = 1'b0; destField = 32'h0;
    check(exp, req);
  endtask

  task automatic tReset;
    check(1'b0, "R1 reset");
    @(negedge clk); check(1'b0, "R1 reset idle");
  endtask

  task automatic tLegPhys;
    selfId = 32'h0000_0023;
    sendOne(1'b0, 1'b0, 32'h23, 1'b1, "R2 hit");
    sendOne(1'b0, 1'b0, 32'h22, 1'b0, "R2 miss");
    sendOne(1'b0, 1'b0, 32'hFF, 1'b1, "R3 broadcast");
    selfId = 32'h0000_00FF;
    sendOne(1'b0, 1'b0, 32'hFF, 1'b1, "R3 broadcast equals own id");
    sendOne(1'b0, 1'b0, 32'hFE, 1'b0, "R2 miss near broadcast");
  endtask

  task automatic tLegLog;
    logicalReg = 32'h0000_0010;
    sendOne(1'b0, 1'b1, 32'h10, 1'b1, "R4 single bit");
    sendOne(1'b0, 1'b1, 32'h93, 1'b1, "R4 multi bit");
    sendOne(1'b0, 1'b1, 32'h6F, 1'b0, "R4 no overlap");
  endtask

  task automatic tLegIgnoreUpper;
    selfId = 32'hABCD_EF41; logicalReg = 32'hFFFF_FF02;
    sendOne(1'b0, 1'b0, 32'h1234_5641, 1'b1, "R8 phys upper ignored");
    sendOne(1'b0, 1'b1, 32'hFFFF_FF01, 1'b0, "R8 logical upper ignored");
    sendOne(1'b0, 1'b1, 32'h0000_0002, 1'b1, "R8 logical low overlap");
  endtask

  task automatic tExtPhys;
    selfId = 32'h0001_0041;
    sendOne(1'b1, 1'b0, 32'h0001_0041, 1'b1, "R5 hit");
    sendOne(1'b1, 1'b0, 32'h0000_0041, 1'b0, "R5 upper bit differs");
    sendOne(1'b1, 1'b0, 32'h8001_0041, 1'b0, "R5 msb differs");
    sendOne(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, "R6 broadcast");
    sendOne(1'b1, 1'b0, 32'h0000_00FF, 1'b0, "R6 legacy broadcast not ext");
    selfId = 32'hFFFF_FFFF;
    sendOne(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, "R6 broadcast equals own id");
  endtask

  task automatic tExtLog;
    logicalReg = 32'h0005_0200;
    sendOne(1'b1, 1'b1, 32'h0005_0300, 1'b1, "R7 hit");
    sendOne(1'b1, 1'b1, 32'h0004_0200, 1'b0, "R7 cluster miss");
    sendOne(1'b1, 1'b1, 32'h0005_0100, 1'b0, "R7 bitmap miss");
  endtask

  task automatic tZeroLogical;
    logicalReg = 32'h0000_0000;
    sendOne(1'b1, 1'b1, 32'h0, 1'b0, "R9 ext zero");
    logicalReg = 32'hFFFF_FFFF;
    sendOne(1'b0, 1'b1, 32'h0, 1'b0, "R9 legacy zero");
  endtask

  task automatic tBackToBack;
    selfId = 32'h0000_0007; logicalReg = 32'h0000_0004;
    @(negedge clk); setMsg(1'b0, 1'b0, 32'h07);
    @(negedge clk); setMsg(1'b0, 1'b1, 32'h08); check(1'b1, "R1 b2b first");
    @(negedge clk); setMsg(1'b0, 1'b1, 32'h04); check(1'b0, "R1 b2b second");
    @(negedge clk); msgValid = 1'b0;           check(1'b1, "R1 b2b third");
    @(negedge clk);                            check(1'b0, "R1 idle after burst");
    destField = 32'h07; destLogical = 1'b0;
    @(negedge clk);                            check(1'b0, "R1 matching field without valid");
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    #1;
    tReset();
    @(negedge clk); rstN = 1'b1;
    tReset();
    tLegPhys();
    tLegLog();
    tLegIgnoreUpper();
    tExtPhys();
    tExtLog();
    tZeroLogical();
    tBackToBack();
    finishRun();
  end
endmodule